// File: doc/BRIEF.md
# Multi-Lane Sync Deskew Aligner

This block sits after the per-lane word aligners of a high-speed serial receiver. It takes one byte-aligned stream per data lane, and each lane has a one-cycle strobe that marks its sync byte. The transmitter puts the sync byte on every lane in the same byte-clock cycle, one cycle before the packet header. Lanes can still reach this block up to a few cycles apart. The block measures each lane's lateness against the earliest sync strobe. It then delays the early lanes by the difference, so that the bytes after the sync byte come out on the same cycle on all lanes, together with one common ready flag.

A run-time lane count selects how many low-numbered lanes take part. Lanes above that count are left out of the lock decision and drive zero. If an enabled lane fails to report its sync within the tolerated window, a one-cycle error pulse is raised and the block hunts again. Dropping the high-speed enable clears the lock, and the next sync sequence re-arms it. A build-time option replaces the deskew logic with an independent per-lane pass-through.

Top module: `lane_deskew`

## Requirements
- R1: While reset is high and in the first cycle after it, `ready` and `skew_err` are 0 and every lane of `out_data` is zero.
- R2: With deskew built in, `ready` rises on the clock edge after the edge at which the last enabled lane's sync strobe is sampled. This holds when all enabled strobes fall within `MAX_SKEW` cycles of the first one.
- R3: Once `ready` is high, each enabled lane `l` of `out_data` (bits `l*DATA_W +: DATA_W`) presents a new byte every cycle. The first ready cycle shows the byte that followed each lane's sync byte, and the following cycles show the later bytes in order, identically aligned across lanes.
- R4: `lane_cnt_m1` holds the enabled lane count minus one, and it enables lanes 0 through `lane_cnt_m1`. Sync strobes on higher lanes have no effect on lock timing or on the error pulse.
- R5: Lanes above `lane_cnt_m1` drive zero on `out_data`.
- R6: With deskew built in, `out_data` is all zero whenever `ready` is low.
- R7: Suppose the first enabled sync is sampled in cycle F and some enabled lane has not synced by cycle F+`MAX_SKEW`. Then `skew_err` is high for exactly the one cycle after that edge, `ready` stays low, and hunting restarts.
- R8: When `hs_enable` is sampled low, `ready` is 0 after that edge, the outputs are zero, and the block hunts for a fresh sync once `hs_enable` returns high.
- R9: Sync strobes that arrive after lock on an already locked lane do not change alignment or `ready`.
- R10: With `DESKEW_EN` = 0, each enabled lane's output is its input registered once. `ready` rises on the edge at which every enabled lane has shown its sync strobe since `hs_enable` went high, and `skew_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| hs_enable | input | 1 | High-speed receive enable; low clears lock |
| lane_cnt_m1 | input | CNT_W | Enabled lane count minus one |
| lane_data | input | NUM_LANES*DATA_W | Word-aligned bytes, lane l at bits l*DATA_W |
| lane_sync | input | NUM_LANES | Per-lane sync byte strobe |
| out_data | output | NUM_LANES*DATA_W | Deskewed bytes, same lane layout |
| ready | output | 1 | All enabled lanes aligned |
| skew_err | output | 1 | One-cycle pulse when the skew window expires |

## Verification
The bench uses four lanes, eight-bit bytes and a three-cycle skew window. It builds one instance with deskew and a second with the pass-through option, and both see the same stimulus. For every lane count from one to four, it sweeps each enabled lane's sync offset over 0 to 4 cycles, which covers every in-window skew pattern and every pattern one cycle outside the window. In every case the disabled lanes sync first, and lane 0 repeats its strobe after lock. Between cases `hs_enable` is held low, so each case also exercises the re-arm path.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;

    typedef enum logic [1:0] {
        DSK_HUNT = 2'd0,
        DSK_WAIT = 2'd1,
        DSK_LOCK = 2'd2
    } dsk_state_e;

    // Thermometer mask with the low (cnt_m1 + 1) bits set.
    function automatic logic [31:0] lane_mask(input int unsigned cnt_m1);
        logic [32:0] m;
        m = (33'd1 << (cnt_m1 + 1)) - 33'd1;
        return m[31:0];
    endfunction

endpackage

// File: rtl/lane_delay_line.sv
module lane_delay_line #(
    parameter int DATA_W   = 8,
    parameter int MAX_SKEW = 3,
    parameter int SEL_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic [SEL_W-1:0]  sel,
    input  logic              pass,
    output logic [DATA_W-1:0] dout
);
    // taps[0] is the live byte, taps[k] the byte from k cycles back.
    logic [DATA_W-1:0] taps [0:MAX_SKEW];

    assign taps[0] = din;

    for (genvar i = 1; i <= MAX_SKEW; i++) begin : g_stage
        logic [DATA_W-1:0] stage_q;
        always_ff @(posedge clk) begin
            if (rst) stage_q <= '0;
            else     stage_q <= taps[i-1];
        end
        assign taps[i] = stage_q;
    end

    always_ff @(posedge clk) begin
        if (rst)       dout <= '0;
        else if (pass) dout <= taps[sel];
        else           dout <= '0;
    end
endmodule

// File: rtl/skew_tracker.sv
module skew_tracker
    import lane_deskew_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int MAX_SKEW  = 3,
    parameter int SEL_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       hs_enable,
    input  logic [NUM_LANES-1:0]       en_mask,
    input  logic [NUM_LANES-1:0]       lane_sync,
    output logic                       locked,
    output logic                       skew_err,
    output logic [NUM_LANES*SEL_W-1:0] lane_dly
);
    dsk_state_e           state;
    logic [NUM_LANES-1:0] seen;
    logic [SEL_W-1:0]     cnt;
    logic [SEL_W-1:0]     arrive [NUM_LANES];
    logic [NUM_LANES-1:0] fresh;
    logic                 all_now;
    logic                 hunting;

    assign fresh   = lane_sync & en_mask & ~seen;
    assign all_now = &(seen | fresh | ~en_mask);
    assign hunting = (state != DSK_LOCK);
    assign locked  = (state == DSK_LOCK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= DSK_HUNT;
            seen     <= '0;
            cnt      <= '0;
            skew_err <= 1'b0;
            lane_dly <= '0;
            for (int l = 0; l < NUM_LANES; l++) arrive[l] <= '0;
        end else begin
            skew_err <= 1'b0;
            if (!hs_enable) begin
                state <= DSK_HUNT;
                seen  <= '0;
                cnt   <= '0;
            end else if (hunting) begin
                for (int l = 0; l < NUM_LANES; l++) begin
                    if (fresh[l]) arrive[l] <= cnt;
                    lane_dly[l*SEL_W +: SEL_W] <= fresh[l] ? '0 : (cnt - arrive[l]);
                end
                if (all_now) begin
                    state <= DSK_LOCK;
                end else if (state == DSK_WAIT && cnt == SEL_W'(MAX_SKEW)) begin
                    skew_err <= 1'b1;
                    state    <= DSK_HUNT;
                    seen     <= '0;
                    cnt      <= '0;
                end else if (state == DSK_WAIT || |fresh) begin
                    state <= DSK_WAIT;
                    seen  <= seen | fresh;
                    cnt   <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
    import lane_deskew_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int DATA_W    = 8,
    parameter int MAX_SKEW  = 3,
    parameter bit DESKEW_EN = 1'b1,
    localparam int CNT_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        hs_enable,
    input  logic [CNT_W-1:0]            lane_cnt_m1,
    input  logic [NUM_LANES*DATA_W-1:0] lane_data,
    input  logic [NUM_LANES-1:0]        lane_sync,
    output logic [NUM_LANES*DATA_W-1:0] out_data,
    output logic                        ready,
    output logic                        skew_err
);
    localparam int SEL_W = (MAX_SKEW > 1) ? $clog2(MAX_SKEW + 1) : 1;

    logic [31:0]          mask_full;
    logic [NUM_LANES-1:0] en_mask;

    assign mask_full = lane_mask(32'(lane_cnt_m1));
    assign en_mask   = mask_full[NUM_LANES-1:0];

    if (DESKEW_EN) begin : g_deskew
        logic                       locked;
        logic [NUM_LANES*SEL_W-1:0] lane_dly;

        skew_tracker #(
            .NUM_LANES(NUM_LANES),
            .MAX_SKEW (MAX_SKEW),
            .SEL_W    (SEL_W)
        ) u_track (
            .clk      (clk),
            .rst      (rst),
            .hs_enable(hs_enable),
            .en_mask  (en_mask),
            .lane_sync(lane_sync),
            .locked   (locked),
            .skew_err (skew_err),
            .lane_dly (lane_dly)
        );

        for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
            lane_delay_line #(
                .DATA_W  (DATA_W),
                .MAX_SKEW(MAX_SKEW),
                .SEL_W   (SEL_W)
            ) u_dly (
                .clk (clk),
                .rst (rst),
                .din (lane_data[l*DATA_W +: DATA_W]),
                .sel (lane_dly[l*SEL_W +: SEL_W]),
                .pass(locked & hs_enable & en_mask[l]),
                .dout(out_data[l*DATA_W +: DATA_W])
            );
        end

        always_ff @(posedge clk) begin
            if (rst) ready <= 1'b0;
            else     ready <= locked & hs_enable;
        end
    end else begin : g_passthru
        logic [NUM_LANES-1:0] seen_p;
        logic [NUM_LANES-1:0] hits;

        assign hits     = lane_sync & en_mask;
        assign skew_err = 1'b0;

        always_ff @(posedge clk) begin
            if (rst || !hs_enable) begin
                seen_p <= '0;
                ready  <= 1'b0;
            end else begin
                seen_p <= seen_p | hits;
                ready  <= &(seen_p | hits | ~en_mask);
            end
        end

        for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst || !en_mask[l]) out_data[l*DATA_W +: DATA_W] <= '0;
                else                    out_data[l*DATA_W +: DATA_W] <= lane_data[l*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/lane_deskew_chk.sv
module lane_deskew_chk #(
    parameter int NUM_LANES = 4,
    parameter int DATA_W    = 8,
    parameter bit DESKEW_EN = 1'b1,
    parameter int CNT_W     = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        hs_enable,
    input logic [CNT_W-1:0]            lane_cnt_m1,
    input logic [NUM_LANES*DATA_W-1:0] out_data,
    input logic                        ready,
    input logic                        skew_err
);
    assert_drop_R8: assert property (@(posedge clk) disable iff (rst)
        !hs_enable |=> !ready);

    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        skew_err |=> !skew_err);

    assert_err_noready_R7: assert property (@(posedge clk) disable iff (rst)
        skew_err |-> !ready);

    assert_rise_enabled_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(hs_enable));

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_chk
        assert_off_lane_zero_R5: assert property (@(posedge clk) disable iff (rst)
            $past(32'(lane_cnt_m1) < l) |-> (out_data[l*DATA_W +: DATA_W] == '0));
    end

    if (DESKEW_EN) begin : g_dsk_chk
        assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
            !ready |-> (out_data == '0));

        assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
            (ready && hs_enable) |=> ready);
    end
endmodule

bind lane_deskew lane_deskew_chk #(
    .NUM_LANES(NUM_LANES),
    .DATA_W   (DATA_W),
    .DESKEW_EN(DESKEW_EN),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hs_enable  (hs_enable),
    .lane_cnt_m1(lane_cnt_m1),
    .out_data   (out_data),
    .ready      (ready),
    .skew_err   (skew_err)
);

// File: tb/lane_deskew_bench.sv
`timescale 1ns/1ps
module lane_deskew_bench;
    localparam int NL = 4;
    localparam int DW = 8;
    localparam int MS = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hs_en = 1'b0;
    logic [1:0]    cnt_m1 = 2'd3;
    logic [NL*DW-1:0] din = '0;
    logic [NL-1:0] sync = '0;
    logic [NL*DW-1:0] dout, pout;
    logic          rdy, perr_unused_rdy;
    logic          err, perr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    lane_deskew #(.NUM_LANES(NL), .DATA_W(DW), .MAX_SKEW(MS), .DESKEW_EN(1'b1)) u_lane_deskew (
        .clk(clk), .rst(rst), .hs_enable(hs_en), .lane_cnt_m1(cnt_m1),
        .lane_data(din), .lane_sync(sync), .out_data(dout), .ready(rdy), .skew_err(err));

    lane_deskew #(.NUM_LANES(NL), .DATA_W(DW), .MAX_SKEW(MS), .DESKEW_EN(1'b0)) u_lane_deskew_pass (
        .clk(clk), .rst(rst), .hs_enable(hs_en), .lane_cnt_m1(cnt_m1),
        .lane_data(din), .lane_sync(sync), .out_data(pout), .ready(perr_unused_rdy), .skew_err(perr));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] lane_byte(input int l, input int k);
        if (k < 0)       return 8'hA0 | 8'(l);
        else if (k == 0) return 8'hB8;
        else             return 8'((l << 5) | k);
    endfunction

    task automatic run_case(input int n, input int off [NL]);
        int m, mx, t_end;
        bit bad;
        cnt_m1 = 2'(n - 1);
        // gap with hs_enable low: re-arm path
        hs_en = 1'b0; sync = '0; din = '0;
        @(posedge clk); @(negedge clk);
        chk("R8 ready low", 32'(rdy), 0);
        chk("R8 outputs zero", dout, 0);
        m = 99; mx = 0;
        for (int l = 0; l < n; l++) begin
            if (off[l] < m)  m  = off[l];
            if (off[l] > mx) mx = off[l];
        end
        bad   = (mx - m) > MS;
        t_end = bad ? m + MS + 1 : mx + 6;
        for (int c = 0; c < t_end; c++) begin
            logic [NL*DW-1:0] drv;
            bit exp_rdy;
            hs_en = 1'b1;
            for (int l = 0; l < NL; l++) begin
                int k;
                k = c - off[l];
                drv[l*DW +: DW] = lane_byte(l, k);
                // lane 0 repeats its strobe after lock (R9)
                sync[l] = (k == 0) || (l == 0 && k == 4);
            end
            din = drv;
            @(posedge clk); @(negedge clk);
            exp_rdy = !bad && (c >= mx + 1);
            chk("R2 ready timing", 32'(rdy), 32'(exp_rdy));
            chk("R7 skew_err", 32'(err), 32'(bad && c == m + MS));
            for (int l = 0; l < NL; l++) begin
                logic [7:0] e;
                if (l >= n)        e = 8'h00;
                else if (exp_rdy)  e = lane_byte(l, c - mx);
                else               e = 8'h00;
                if (l >= n)       chk("R5 disabled lane", 32'(dout[l*DW +: DW]), 32'(e));
                else if (exp_rdy) chk("R3 aligned byte", 32'(dout[l*DW +: DW]), 32'(e));
                else              chk("R6 quiet before ready", 32'(dout[l*DW +: DW]), 32'(e));
                chk("R10 pass data", 32'(pout[l*DW +: DW]),
                    (l < n) ? 32'(drv[l*DW +: DW]) : 32'd0);
            end
            chk("R10 pass ready", 32'(perr_unused_rdy), 32'(c >= mx));
            chk("R10 pass no err", 32'(perr), 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset ready", 32'(rdy), 0);
        chk("R1 reset err", 32'(err), 0);
        chk("R1 reset data", dout, 0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 idle ready", 32'(rdy), 0);
        chk("R1 idle data", dout, 0);
        // R4: lane counts 1..4; disabled lanes sync at offset 0
        for (int n = 1; n <= NL; n++) begin
            int total;
            total = 1;
            for (int i = 0; i < n; i++) total *= 5;
            for (int code = 0; code < total; code++) begin
                int off [NL];
                int v;
                v = code;
                for (int l = 0; l < NL; l++) begin
                    if (l < n) begin
                        off[l] = v % 5;
                        v = v / 5;
                    end else begin
                        off[l] = 0;
                    end
                end
                run_case(n, off);
            end
        end
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule